// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the software-facing register front end of an I/O interrupt controller. A 256-byte memory window holds a few directly addressed locations. The main ones are an 8-bit selector and a 32-bit data port. Through them, software reaches an identity register, a read-only version word, an arbitration word and a table of 64-bit per-pin redirection entries. Each entry is reached as two 32-bit halves. The table lives here, and its full contents are driven out on a flat bus so that the delivery logic can read each pin's vector, mode, trigger, polarity, mask and destination.

The delivery logic returns two kinds of status. It drives a per-pin delivery-status level and remote-IRR set/clear pulses. Software can read these bits but cannot write them. A write to the end-of-interrupt location produces a one-cycle vector pulse. Any accepted write to an entry produces a one-cycle one-hot "reconfigured" strobe for that pin. The delivery logic uses this strobe to re-evaluate an asserted, unmasked level-triggered input.

A small controller sequences the bus side. From `S_IDLE` it moves on each cycle according to the request it sees:
- A read goes to `S_RDATA`, where the registered read data and `bus_rvalid` are presented.
- An accepted entry write goes to `S_RECONF`, where the strobe is driven.
- An end-of-interrupt write goes to `S_EOI`, where the vector pulse is driven.
- Anything else returns to `S_IDLE`.

Every state takes the same transitions, so back-to-back requests are accepted without stalls.

Top module: `irq_regwin`

## Requirements
- R1: After reset, every entry reads as only its mask bit (bit 16) set, i.e. low half 0x00010000 and high half 0. The selector and the identity field read zero. `bus_rvalid`, `eoi_valid` and `reconf` are low.
- R2: Offset 0x00 holds the selector. A write with `bus_be[0]` set loads `bus_wdata[7:0]`, and a read returns it zero-extended. Offsets 0x04 and 0x40, and every unmapped offset, read zero. A write to 0x04 changes nothing.
- R3: A read request in one cycle returns `bus_rdata` with `bus_rvalid` high in the next cycle. `bus_rvalid` is low in every other cycle.
- R4: Selector 0 is the identity register. A window write stores only `bus_wdata[27:24]`, and all other bits read zero. Selector 2 reads the same value as selector 0 and ignores writes.
- R5: Selector 1 is read-only. It returns (NUM_PINS-1) in bits 23:16 and 0x20 in bits 7:0, which is 0x00170020 for 24 pins.
- R6: Selector 0x10+2n addresses the low half of entry n, and 0x10+2n+1 addresses its high half. Writes through the data window at offset 0x10 take effect only when `bus_be` is 4'b1111.
- R7: Selectors 0x03 to 0x0F read zero and ignore writes. Selectors that decode to an entry n >= NUM_PINS read 0xFFFFFFFF and ignore writes.
- R8: Entry bits are laid out as follows: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger 15 (1 = level), mask 16, destination 63:56. A low-half write keeps bit 12 and bit 14. If the written bit 15 is 0 (edge), bit 14 is cleared. Bit 12 follows `dstat_in[n]` one cycle later.
- R9: `irr_set[n]` sets bit 14 of entry n and `irr_clr[n]` clears it, taking effect on the next edge. Clear wins over set, and both win over a same-cycle bus write.
- R10: After every accepted entry write, to either half, `reconf` is one-hot on that pin for exactly one cycle. No other access raises `reconf`.
- R11: A write to offset 0x40 with `bus_be[0]` set drives `eoi_valid` high for the next cycle, with `eoi_vector` equal to the written `bus_wdata[7:0]`.
- R12: Reserved entry bits 55:17 are stored as written. `entries[64n +: 64]` always shows entry n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the window |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_vector | output | 8 | Vector carried by the end-of-interrupt pulse |
| dstat_in | input | NUM_PINS | Per-pin delivery status from delivery logic |
| irr_set | input | NUM_PINS | Per-pin remote IRR set pulse |
| irr_clr | input | NUM_PINS | Per-pin remote IRR clear pulse |
| reconf | output | NUM_PINS | One-hot strobe after an entry write |
| entries | output | NUM_PINS*64 | Flat redirection table, entry n at bits 64n+63:64n |

## Verification
The bench targets the protected fields and the indirect decode.

- **Protected bits.** Remote IRR is set, then the entry is rewritten with the bit clear while in level mode; a design that let software write the bit would read it back as 0. Switching the entry to edge mode must clear the bit; a design that only preserved it would keep reporting a stale in-service state.
- **Decode boundaries.** Selector 0x05, selector 0x40 (the first entry beyond 24 pins) and a half-width data write are each exercised. A decoder that wrapped the index, or accepted partial writes, would corrupt a real entry or return zero instead of all ones.
- **Pulse timing.** The reconfigure and end-of-interrupt pulses are sampled in the cycle after the write and in the cycle after that. A strobe that was late, stuck or aimed at the wrong pin would be reported.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;

    typedef enum logic [2:0] {
        K_ID,
        K_VER,
        K_ARB,
        K_RSVD,
        K_ENT,
        K_OOR
    } sel_kind_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RDATA,
        S_RECONF,
        S_EOI
    } bus_state_t;

    localparam int ENT_W = 64;
    localparam int HALF_W = 32;

    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_SELHI = 8'h04;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] OFF_EOI = 8'h40;

    localparam logic [7:0] SEL_ENT_BASE = 8'h10;
    localparam logic [7:0] VER_CODE = 8'h20;

    localparam int B_DSTAT = 12;
    localparam int B_RIRR = 14;
    localparam int B_TRIG = 15;
    localparam int B_MASK = 16;

endpackage

// File: rtl/irq_sel_decode.sv
module irq_sel_decode
    import irq_regwin_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W = 5
) (
    input  logic [7:0]       sel,
    output sel_kind_t        kind,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);

    logic [7:0] off;
    logic [6:0] n;

    always_comb begin
        off = sel - SEL_ENT_BASE;
        n = off[7:1];
        hi = sel[0];
        idx = IDX_W'(n);
        if (sel == 8'h00) begin
            kind = K_ID;
        end else if (sel == 8'h01) begin
            kind = K_VER;
        end else if (sel == 8'h02) begin
            kind = K_ARB;
        end else if (sel < SEL_ENT_BASE) begin
            kind = K_RSVD;
        end else if (int'(n) < NUM_PINS) begin
            kind = K_ENT;
        end else begin
            kind = K_OOR;
        end
    end

endmodule

// File: rtl/irq_entry_table.sv
module irq_entry_table
    import irq_regwin_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_hi,
    input  logic [HALF_W-1:0]         wr_data,
    input  logic [NUM_PINS-1:0]       dstat_in,
    input  logic [NUM_PINS-1:0]       irr_set,
    input  logic [NUM_PINS-1:0]       irr_clr,
    output logic [NUM_PINS*ENT_W-1:0] entries
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [ENT_W-1:0] ent_q;
        logic hit;
        logic rirr_d;

        assign hit = wr_en && (wr_idx == IDX_W'(p));

        always_comb begin
            if (irr_clr[p]) begin
                rirr_d = 1'b0;
            end else if (irr_set[p]) begin
                rirr_d = 1'b1;
            end else if (hit && !wr_hi && !wr_data[B_TRIG]) begin
                rirr_d = 1'b0;
            end else begin
                rirr_d = ent_q[B_RIRR];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
                ent_q[B_MASK] <= 1'b1;
            end else begin
                if (hit && wr_hi) begin
                    ent_q[63:32] <= wr_data;
                end
                if (hit && !wr_hi) begin
                    ent_q[31:15] <= wr_data[31:15];
                    ent_q[13] <= wr_data[13];
                    ent_q[11:0] <= wr_data[11:0];
                end
                ent_q[B_DSTAT] <= dstat_in[p];
                ent_q[B_RIRR] <= rirr_d;
            end
        end

        assign entries[p*ENT_W +: ENT_W] = ent_q;
    end

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
    import irq_regwin_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [7:0]                bus_addr,
    input  logic [3:0]                bus_be,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      bus_rvalid,
    output logic                      eoi_valid,
    output logic [7:0]                eoi_vector,
    input  logic [NUM_PINS-1:0]       dstat_in,
    input  logic [NUM_PINS-1:0]       irr_set,
    input  logic [NUM_PINS-1:0]       irr_clr,
    output logic [NUM_PINS-1:0]       reconf,
    output logic [NUM_PINS*64-1:0]    entries
);

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [7:0] TOP_PIN = 8'(NUM_PINS - 1);

    bus_state_t state_q, state_d;
    logic [7:0] sel_q;
    logic [3:0] id_q;
    logic [31:0] rdata_q, rd_mux;
    logic [IDX_W-1:0] pin_q;
    logic [7:0] vec_q;

    sel_kind_t dec_kind;
    logic [IDX_W-1:0] dec_idx;
    logic dec_hi;

    logic full_be, rd_req, sel_wr, win_wr, ent_wr, eoi_wr;
    logic [31:0] id_word;

    irq_sel_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
        .sel  (sel_q),
        .kind (dec_kind),
        .idx  (dec_idx),
        .hi   (dec_hi)
    );

    assign full_be = &bus_be;
    assign rd_req = bus_req && !bus_we;
    assign sel_wr = bus_req && bus_we && (bus_addr == OFF_SEL) && bus_be[0];
    assign win_wr = bus_req && bus_we && (bus_addr == OFF_WIN) && full_be;
    assign ent_wr = win_wr && (dec_kind == K_ENT);
    assign eoi_wr = bus_req && bus_we && (bus_addr == OFF_EOI) && bus_be[0];
    assign id_word = {4'h0, id_q, 24'h0};

    irq_entry_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ent_wr),
        .wr_idx   (dec_idx),
        .wr_hi    (dec_hi),
        .wr_data  (bus_wdata),
        .dstat_in (dstat_in),
        .irr_set  (irr_set),
        .irr_clr  (irr_clr),
        .entries  (entries)
    );

    // Read data selection for the current request
    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFF_SEL) begin
            rd_mux = {24'h0, sel_q};
        end else if (bus_addr == OFF_WIN) begin
            unique case (dec_kind)
                K_ID, K_ARB: rd_mux = id_word;
                K_VER:       rd_mux = {8'h00, TOP_PIN, 8'h00, VER_CODE};
                K_RSVD:      rd_mux = '0;
                K_ENT:       rd_mux = entries[32*(2*int'(dec_idx) + int'(dec_hi)) +: 32];
                K_OOR:       rd_mux = '1;
                default:     rd_mux = '0;
            endcase
        end
    end

    // Next state: every state takes the same transitions
    always_comb begin
        if (rd_req) begin
            state_d = S_RDATA;
        end else if (ent_wr) begin
            state_d = S_RECONF;
        end else if (eoi_wr) begin
            state_d = S_EOI;
        end else begin
            state_d = S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sel_q <= '0;
            id_q <= '0;
            rdata_q <= '0;
            pin_q <= '0;
            vec_q <= '0;
        end else begin
            state_q <= state_d;
            if (sel_wr) begin
                sel_q <= bus_wdata[7:0];
            end
            if (win_wr && (dec_kind == K_ID)) begin
                id_q <= bus_wdata[27:24];
            end
            if (rd_req) begin
                rdata_q <= rd_mux;
            end
            if (ent_wr) begin
                pin_q <= dec_idx;
            end
            if (eoi_wr) begin
                vec_q <= bus_wdata[7:0];
            end
        end
    end

    // Outputs per state
    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata = '0;
        eoi_valid = 1'b0;
        eoi_vector = '0;
        reconf = '0;
        unique case (state_q)
            S_IDLE: begin
            end
            S_RDATA: begin
                bus_rvalid = 1'b1;
                bus_rdata = rdata_q;
            end
            S_RECONF: begin
                reconf[pin_q] = 1'b1;
            end
            S_EOI: begin
                eoi_valid = 1'b1;
                eoi_vector = vec_q;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/irq_regwin_chk.sv
module irq_regwin_chk #(
    parameter int NUM_PINS = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_req,
    input logic                   bus_we,
    input logic [7:0]             bus_addr,
    input logic [3:0]             bus_be,
    input logic [31:0]            bus_wdata,
    input logic                   bus_rvalid,
    input logic                   eoi_valid,
    input logic [7:0]             eoi_vector,
    input logic [NUM_PINS-1:0]    dstat_in,
    input logic [NUM_PINS-1:0]    irr_set,
    input logic [NUM_PINS-1:0]    irr_clr,
    input logic [NUM_PINS-1:0]    reconf,
    input logic [NUM_PINS*64-1:0] entries,
    input logic [7:0]             sel_q
);

    a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    a_r3_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));

    a_r10_reconf_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reconf));

    a_r10_reconf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|reconf) |-> $past(bus_req && bus_we && bus_addr == 8'h10 &&
                            bus_be == 4'hF && sel_q >= 8'h10));

    a_r11_eoi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> ($past(bus_req && bus_we && bus_addr == 8'h40 && bus_be[0]) &&
                       eoi_vector == $past(bus_wdata[7:0])));

    a_r8_dstat_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (entries[12] == $past(dstat_in[0])));

    a_r8_edge_clears_irr: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && bus_req && bus_we && bus_addr == 8'h10 && bus_be == 4'hF &&
              sel_q == 8'h10 && !bus_wdata[15] && !irr_set[0]) |-> !entries[14]);

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && irr_clr[0]) |-> !entries[14]);

endmodule

bind irq_regwin irq_regwin_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .dstat_in   (dstat_in),
    .irr_set    (irr_set),
    .irr_clr    (irr_clr),
    .reconf     (reconf),
    .entries    (entries),
    .sel_q      (sel_q)
);

// File: tb/irq_regwin_tb.sv
module irq_regwin_tb;

    localparam int NP = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0;
    logic bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [3:0] bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_rvalid;
    logic eoi_valid;
    logic [7:0] eoi_vector;
    logic [NP-1:0] dstat_in = '0;
    logic [NP-1:0] irr_set = '0;
    logic [NP-1:0] irr_clr = '0;
    logic [NP-1:0] reconf;
    logic [NP*64-1:0] entries;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    irq_regwin #(.NUM_PINS(NP)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .dstat_in   (dstat_in),
        .irr_set    (irr_set),
        .irr_clr    (irr_clr),
        .reconf     (reconf),
        .entries    (entries)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp;
        logic [7:0]  rq;
    } row_t;

    localparam int NROWS = 30;
    localparam row_t ROWS [NROWS] = '{
        '{1'b1, 8'h00, 4'hF, 32'h000000A5, 1'b0, 32'h0,        8'd2},  // R2 load selector
        '{1'b0, 8'h00, 4'hF, 32'h0,        1'b1, 32'h000000A5, 8'd2},  // R2 selector readback
        '{1'b1, 8'h04, 4'hF, 32'hFFFFFFFF, 1'b0, 32'h0,        8'd2},  // R2 write to 0x04
        '{1'b0, 8'h04, 4'hF, 32'h0,        1'b1, 32'h0,        8'd2},  // R2 0x04 reads zero
        '{1'b0, 8'h00, 4'hF, 32'h0,        1'b1, 32'h000000A5, 8'd2},  // R2 selector untouched
        '{1'b1, 8'h00, 4'hF, 32'h00000000, 1'b0, 32'h0,        8'd4},
        '{1'b1, 8'h10, 4'hF, 32'h1F3E5D7C, 1'b0, 32'h0,        8'd4},  // R4 identity write
        '{1'b0, 8'h10, 4'hF, 32'h0,        1'b1, 32'h0F000000, 8'd4},  // R4 only 27:24 kept
        '{1'b1, 8'h00, 4'hF, 32'h00000002, 1'b0, 32'h0,        8'd4},
        '{1'b1, 8'h10, 4'hF, 32'hFFFFFFFF, 1'b0, 32'h0,        8'd4},  // R4 arbitration write
        '{1'b0, 8'h10, 4'hF, 32'h0,        1'b1, 32'h0F000000, 8'd4},  // R4 arbitration mirrors
        '{1'b1, 8'h00, 4'hF, 32'h00000001, 1'b0, 32'h0,        8'd5},
        '{1'b1, 8'h10, 4'hF, 32'h00000000, 1'b0, 32'h0,        8'd5},  // R5 version write
        '{1'b0, 8'h10, 4'hF, 32'h0,        1'b1, 32'h00170020, 8'd5},  // R5 version value
        '{1'b1, 8'h00, 4'hF, 32'h00000005, 1'b0, 32'h0,        8'd7},
        '{1'b1, 8'h10, 4'hF, 32'hDEADBEEF, 1'b0, 32'h0,        8'd7},
        '{1'b0, 8'h10, 4'hF, 32'h0,        1'b1, 32'h0,        8'd7},  // R7 reserved selector
        '{1'b1, 8'h00, 4'hF, 32'h00000040, 1'b0, 32'h0,        8'd7},
        '{1'b1, 8'h10, 4'hF, 32'h00000000, 1'b0, 32'h0,        8'd7},
        '{1'b0, 8'h10, 4'hF, 32'h0,        1'b1, 32'hFFFFFFFF, 8'd7},  // R7 pin 24 out of range
        '{1'b1, 8'h00, 4'hF, 32'h00000011, 1'b0, 32'h0,        8'd6},
        '{1'b1, 8'h10, 4'hF, 32'h5F000000, 1'b0, 32'h0,        8'd6},  // R6 pin 0 high half
        '{1'b0, 8'h10, 4'hF, 32'h0,        1'b1, 32'h5F000000, 8'd6},
        '{1'b1, 8'h10, 4'h3, 32'h00000000, 1'b0, 32'h0,        8'd6},  // R6 half-width write
        '{1'b0, 8'h10, 4'hF, 32'h0,        1'b1, 32'h5F000000, 8'd6},  // R6 ignored
        '{1'b1, 8'h00, 4'hF, 32'h00000013, 1'b0, 32'h0,        8'd12},
        '{1'b1, 8'h10, 4'hF, 32'h12345678, 1'b0, 32'h0,        8'd12}, // R12 reserved bits
        '{1'b0, 8'h10, 4'hF, 32'h0,        1'b1, 32'h12345678, 8'd12},
        '{1'b1, 8'h00, 4'hF, 32'h00000014, 1'b0, 32'h0,        8'd1},
        '{1'b0, 8'h10, 4'hF, 32'h0,        1'b1, 32'h00010000, 8'd1}   // R1 pin 2 reset value
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One bus access; returns at the negedge after the capturing posedge
    task automatic op(input logic we, input logic [7:0] addr, input logic [3:0] be,
                      input logic [31:0] wd);
        @(negedge clk);
        bus_req = 1'b1;
        bus_we = we;
        bus_addr = addr;
        bus_be = be;
        bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] sel, input string rq, input logic [31:0] exp);
        op(1'b1, 8'h00, 4'hF, {24'h0, sel});
        op(1'b0, 8'h10, 4'hF, 32'h0);
        check({rq, " rvalid"}, {31'h0, bus_rvalid}, 32'h1);
        check(rq, bus_rdata, exp);
    endtask

    task automatic wr_entry(input logic [7:0] sel, input logic [31:0] wd);
        op(1'b1, 8'h00, 4'hF, {24'h0, sel});
        op(1'b1, 8'h10, 4'hF, wd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 rvalid", {31'h0, bus_rvalid}, 32'h0);
        check("R1 eoi", {31'h0, eoi_valid}, 32'h0);
        check("R1 reconf", 32'(reconf), 32'h0);
        for (int p = 0; p < NP; p++) begin
            check("R1 entry low", entries[p*64 +: 32], 32'h00010000);
            check("R1 entry high", entries[p*64+32 +: 32], 32'h0);
        end
        op(1'b0, 8'h00, 4'hF, 32'h0);
        check("R1 selector", bus_rdata, 32'h0);
        op(1'b0, 8'h10, 4'hF, 32'h0);
        check("R1 identity", bus_rdata, 32'h0);

        // Table walk
        for (int i = 0; i < NROWS; i++) begin
            op(ROWS[i].we, ROWS[i].addr, ROWS[i].be, ROWS[i].wd);
            if (ROWS[i].chk) begin
                check($sformatf("R%0d row %0d rvalid", ROWS[i].rq, i), {31'h0, bus_rvalid}, 32'h1);
                check($sformatf("R%0d row %0d", ROWS[i].rq, i), bus_rdata, ROWS[i].exp);
            end else begin
                check($sformatf("R3 row %0d no rvalid on write", i), {31'h0, bus_rvalid}, 32'h0);
            end
        end
        check("R12 entries port pin1 high", entries[64+32 +: 32], 32'h12345678);
        check("R6 entries port pin0 dest", {24'h0, entries[63:56]}, 32'h5F);
        op(1'b0, 8'h40, 4'hF, 32'h0);
        check("R2 0x40 reads zero", bus_rdata, 32'h0);
        op(1'b0, 8'h20, 4'hF, 32'h0);
        check("R2 unmapped reads zero", bus_rdata, 32'h0);

        // R10 strobe after an entry write, pin 3 low half (selector 0x16)
        dstat_in[3] = 1'b1;
        wr_entry(8'h16, 32'h0000A031);
        check("R10 reconf pin3", 32'(reconf), 32'h00000008);
        @(negedge clk);
        check("R10 reconf one cycle", 32'(reconf), 32'h0);
        op(1'b1, 8'h00, 4'hF, 32'h16);
        check("R10 no reconf on selector write", 32'(reconf), 32'h0);

        // R8 / R9 protected bits
        @(negedge clk);
        irr_set[3] = 1'b1;
        @(negedge clk);
        irr_set[3] = 1'b0;
        rd(8'h16, "R9 set remote IRR", 32'h0000F031);
        wr_entry(8'h16, 32'h0000A031);
        rd(8'h16, "R8 level write keeps status bits", 32'h0000F031);
        wr_entry(8'h16, 32'h00002031);
        rd(8'h16, "R8 edge write clears remote IRR", 32'h00003031);
        wr_entry(8'h16, 32'h0000A031);
        @(negedge clk);
        irr_set[3] = 1'b1;
        irr_clr[3] = 1'b1;
        @(negedge clk);
        irr_set[3] = 1'b0;
        irr_clr[3] = 1'b0;
        rd(8'h16, "R9 clear wins over set", 32'h0000B031);
        dstat_in[3] = 1'b0;
        @(negedge clk);
        rd(8'h16, "R8 status follows input", 32'h0000A031);

        // R11 end-of-interrupt pulse
        op(1'b1, 8'h40, 4'h1, 32'h12345677);
        check("R11 eoi valid", {31'h0, eoi_valid}, 32'h1);
        check("R11 eoi vector", {24'h0, eoi_vector}, 32'h77);
        @(negedge clk);
        check("R11 eoi one cycle", {31'h0, eoi_valid}, 32'h0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule